// File: doc/BRIEF.md
# Fan Drive Bus-Activity Watchdog

This block owns the drive codes for four fan channels. At power-on it takes its settings from strap pins rather than from a register. A three-level strap sets the starting drive for every channel. A second strap chooses whether all fans first get a burst at full scale to spin them up. A third strap chooses whether a silent host is treated as a fault. Once running, the host sets each channel's 8-bit drive code through a write port fed by the serial slave.

When the watchdog is enabled, every activity pulse from the serial slave restarts a timeout. The timeout is counted in whole seconds by a prescaler derived from the clock-frequency parameter, and a strap selects a length of 2, 6 or 10 seconds. If the host stays quiet for the whole timeout, all channels go to full scale and a sticky force indicator is raised. Both stay in place until the host writes a drive code. That write clears the indicator and brings back the host-written codes.

Top module: `fan_watchdog_ctrl`

## Requirements
- R1: From reset until the straps are captured (the third rising clock edge after rst_n is released), every channel outputs 0xFF and force_full is low.
- R2: At capture, all channel codes load the start level chosen by strap_start_lvl: 2'b00 gives 0x00, 2'b01 gives 0xC0, and 2'b10 or 2'b11 gives 0xFF.
- R3: When strap_spin_en is high at capture, every channel outputs 0xFF for SPIN_CYCLES cycles starting at the capture edge, and then shows its stored code; when it is low, the stored code shows from the capture edge.
- R4: A host write (host_wr_valid high after capture) stores host_wr_code into the channel numbered host_wr_ch (channel n occupies drive_code[8n+7:8n]). The new code shows from the next cycle, and the other channels are unchanged.
- R5: With the watchdog enabled, force_full rises exactly T*CLK_HZ cycles after the last restart if no activity arrives in between. T is 2 s for strap_wdog_sel 2'b00, 6 s for 2'b01, and 10 s for 2'b10 or 2'b11. The capture edge counts as a restart.
- R6: A bus_act pulse or a host write restarts the full timeout, so a host that is active more often than the timeout never raises force_full.
- R7: While force_full is high, every channel outputs 0xFF. A host write clears force_full on the next cycle and brings back the stored codes, including the code just written.
- R8: A bus_act pulse without a write leaves force_full set.
- R9: With strap_wdog_en low at capture, force_full never rises, however long the bus stays idle.
- R10: Strap values are sampled only at capture, and changes after capture have no effect on the drive level or on the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| strap_start_lvl | input | 2 | Start drive strap: 00 = off, 01 = 75 %, 1x = full |
| strap_spin_en | input | 1 | Spin-up burst enable strap |
| strap_wdog_en | input | 1 | Watchdog enable strap |
| strap_wdog_sel | input | 2 | Timeout strap: 00 = 2 s, 01 = 6 s, 1x = 10 s |
| bus_act | input | 1 | One-cycle pulse for each host transaction seen by the serial slave |
| host_wr_valid | input | 1 | Host drive-code write strobe |
| host_wr_ch | input | 2 | Channel number for the write |
| host_wr_code | input | 8 | Drive code to store |
| drive_code | output | 32 | Four 8-bit channel drive codes, channel 0 in the low byte |
| force_full | output | 1 | Sticky indicator that the watchdog has forced full drive |

## Verification
The hardest situation to reach from the ports is an activity pulse arriving one cycle before the timeout expires. The exact expiry edge has to be hit, and a spin-up burst or an earlier write may already have used up part of the window. The bench therefore keeps its own count of cycles since the last restart, covering the capture edge, every pulse and every write. It spaces random pulses and writes up to one cycle short of the timeout, and then checks force_full on both sides of the predicted expiry edge. Strap changes after capture and pulses that arrive while the fans are forced are applied as directed cases.

// File: rtl/fanwd_pkg.sv
package fanwd_pkg;
  localparam int CODE_W = 8;
  localparam int SEC_W  = 4;
  localparam logic [CODE_W-1:0] CODE_FULL = 8'hFF;
  localparam logic [CODE_W-1:0] CODE_3Q   = 8'hC0;
  localparam logic [CODE_W-1:0] CODE_OFF  = 8'h00;

  // start drive selected by the three-level strap
  function automatic logic [CODE_W-1:0] start_code(input logic [1:0] lvl);
    case (lvl)
      2'b00:   return CODE_OFF;
      2'b01:   return CODE_3Q;
      default: return CODE_FULL;
    endcase
  endfunction

  // watchdog length in seconds selected by strap
  function automatic logic [SEC_W-1:0] timeout_secs(input logic [1:0] sel);
    case (sel)
      2'b00:   return SEC_W'(2);
      2'b01:   return SEC_W'(6);
      default: return SEC_W'(10);
    endcase
  endfunction
endpackage

// File: rtl/fanwd_rst_sync.sv
module fanwd_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign srst_n = sync_q;
endmodule

// File: rtl/fanwd_timer.sv
module fanwd_timer #(
  parameter int CLK_HZ = 50_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       enable,
  input  logic [1:0] sel,
  input  logic       clear,
  output logic       expired
);
  import fanwd_pkg::*;

  localparam int PRE_W = (CLK_HZ > 1) ? $clog2(CLK_HZ) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_HZ - 1);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [SEC_W-1:0] sec_q, sec_d;
  logic             exp_q, exp_d;
  logic [SEC_W-1:0] sec_last;
  logic             sec_tick;

  assign sec_last = timeout_secs(sel) - SEC_W'(1);
  assign sec_tick = (pre_q == PRE_LAST);

  always_comb begin
    pre_d = pre_q;
    sec_d = sec_q;
    exp_d = exp_q;
    if (restart) begin
      pre_d = '0;
      sec_d = '0;
    end else if (enable && !exp_q) begin
      if (sec_tick) begin
        pre_d = '0;
        if (sec_q == sec_last) begin
          sec_d = '0;
          exp_d = 1'b1;
        end else begin
          sec_d = sec_q + SEC_W'(1);
        end
      end else begin
        pre_d = pre_q + PRE_W'(1);
      end
    end
    if (clear) exp_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      sec_q <= '0;
      exp_q <= 1'b0;
    end else begin
      pre_q <= pre_d;
      sec_q <= sec_d;
      exp_q <= exp_d;
    end
  end

  assign expired = exp_q;
endmodule

// File: rtl/fanwd_spin.sv
module fanwd_spin #(
  parameter int SPIN_CYCLES = 1_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic spin_en,
  output logic active
);
  localparam int SPIN_W = $clog2(SPIN_CYCLES + 1);

  logic [SPIN_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start)
      cnt_d = spin_en ? SPIN_W'(SPIN_CYCLES) : '0;
    else if (cnt_q != '0)
      cnt_d = cnt_q - SPIN_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign active = (cnt_q != '0);
endmodule

// File: rtl/fanwd_chan.sv
module fanwd_chan #(
  parameter int CH_W = 2,
  parameter int IDX  = 0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load,
  input  logic [fanwd_pkg::CODE_W-1:0] load_code,
  input  logic                        wr_en,
  input  logic [CH_W-1:0]             wr_ch,
  input  logic [fanwd_pkg::CODE_W-1:0] wr_code,
  input  logic                        hold_full,
  output logic [fanwd_pkg::CODE_W-1:0] drive
);
  import fanwd_pkg::*;

  logic [CODE_W-1:0] code_q, code_d;
  logic              hit;

  assign hit = wr_en && (wr_ch == CH_W'(IDX));

  always_comb begin
    code_d = code_q;
    if (load)     code_d = load_code;
    else if (hit) code_d = wr_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= '0;
    else        code_q <= code_d;
  end

  assign drive = hold_full ? CODE_FULL : code_q;
endmodule

// File: rtl/fan_watchdog_ctrl.sv
module fan_watchdog_ctrl #(
  parameter int NUM_CH      = 4,
  parameter int CLK_HZ      = 50_000_000,
  parameter int SPIN_CYCLES = 1_000_000,
  localparam int CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int DW         = fanwd_pkg::CODE_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           strap_start_lvl,
  input  logic                 strap_spin_en,
  input  logic                 strap_wdog_en,
  input  logic [1:0]           strap_wdog_sel,
  input  logic                 bus_act,
  input  logic                 host_wr_valid,
  input  logic [CH_W-1:0]      host_wr_ch,
  input  logic [DW-1:0]        host_wr_code,
  output logic [NUM_CH*DW-1:0] drive_code,
  output logic                 force_full
);
  import fanwd_pkg::*;

  logic       srst_n;
  logic       init_done_q, init_done_d;
  logic       wen_q, wen_d;
  logic [1:0] wsel_q, wsel_d;
  logic       capture;
  logic       wr_ok;
  logic       restart;
  logic       spin_active;
  logic       hold_full;
  logic [DW-1:0] start_lvl_code;

  fanwd_rst_sync rst_sync_i (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  assign capture        = !init_done_q;
  assign wr_ok          = host_wr_valid && init_done_q;
  assign restart        = capture || bus_act || wr_ok;
  assign start_lvl_code = start_code(strap_start_lvl);

  always_comb begin
    init_done_d = init_done_q;
    wen_d       = wen_q;
    wsel_d      = wsel_q;
    if (capture) begin
      init_done_d = 1'b1;
      wen_d       = strap_wdog_en;
      wsel_d      = strap_wdog_sel;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      init_done_q <= 1'b0;
      wen_q       <= 1'b0;
      wsel_q      <= 2'b00;
    end else begin
      init_done_q <= init_done_d;
      wen_q       <= wen_d;
      wsel_q      <= wsel_d;
    end
  end

  fanwd_timer #(.CLK_HZ(CLK_HZ)) timer_i (
    .clk     (clk),
    .rst_n   (srst_n),
    .restart (restart),
    .enable  (wen_q),
    .sel     (wsel_q),
    .clear   (wr_ok),
    .expired (force_full)
  );

  fanwd_spin #(.SPIN_CYCLES(SPIN_CYCLES)) spin_i (
    .clk     (clk),
    .rst_n   (srst_n),
    .start   (capture),
    .spin_en (strap_spin_en),
    .active  (spin_active)
  );

  assign hold_full = force_full || spin_active || !init_done_q;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    fanwd_chan #(.CH_W(CH_W), .IDX(g)) chan_i (
      .clk       (clk),
      .rst_n     (srst_n),
      .load      (capture),
      .load_code (start_lvl_code),
      .wr_en     (wr_ok),
      .wr_ch     (host_wr_ch),
      .wr_code   (host_wr_code),
      .hold_full (hold_full),
      .drive     (drive_code[g*DW +: DW])
    );
  end
endmodule

// File: rtl/fanwd_checker.sv
module fanwd_checker #(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 2,
  parameter int DW     = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_act,
  input logic                 host_wr_valid,
  input logic [CH_W-1:0]      host_wr_ch,
  input logic [DW-1:0]        host_wr_code,
  input logic [NUM_CH*DW-1:0] drive_code,
  input logic                 force_full,
  input logic                 init_done_q,
  input logic                 spin_active,
  input logic                 wen_q
);
  logic            last_ok_q;
  logic [CH_W-1:0] last_ch_q;
  logic [DW-1:0]   last_code_q;
  logic [DW-1:0]   last_slice;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_ok_q   <= 1'b0;
      last_ch_q   <= '0;
      last_code_q <= '0;
    end else begin
      last_ok_q   <= host_wr_valid && init_done_q && !spin_active;
      last_ch_q   <= host_wr_ch;
      last_code_q <= host_wr_code;
    end
  end

  assign last_slice = drive_code[int'(last_ch_q)*DW +: DW];

  // R1: full drive and no fault before straps are taken
  p_pre_capture_full_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done_q |-> (drive_code == '1) && !force_full);

  // R4: a write lands in its own channel one cycle later
  p_write_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    last_ok_q |-> (last_slice == last_code_q));

  // R6: a timeout never completes on the edge that follows activity
  p_quiet_before_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(force_full) |-> !$past(bus_act));

  // R7: forced state drives every channel full
  p_forced_all_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    force_full |-> (drive_code == '1));

  // R7: a host write clears the fault
  p_write_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr_valid && init_done_q) |=> !force_full);

  // R8: the fault is sticky without a write
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (force_full && !host_wr_valid) |=> force_full);

  // R9: a disabled watchdog never forces
  p_disabled_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wen_q |-> !force_full);
endmodule

bind fan_watchdog_ctrl fanwd_checker #(
  .NUM_CH (NUM_CH),
  .CH_W   (CH_W),
  .DW     (DW)
) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_act       (bus_act),
  .host_wr_valid (host_wr_valid),
  .host_wr_ch    (host_wr_ch),
  .host_wr_code  (host_wr_code),
  .drive_code    (drive_code),
  .force_full    (force_full),
  .init_done_q   (init_done_q),
  .spin_active   (spin_active),
  .wen_q         (wen_q)
);

// File: tb/fan_watchdog_ctrl_tb.sv
`timescale 1ns/1ps
module fan_watchdog_ctrl_tb_top;
  localparam int HZ   = 10;
  localparam int SPIN = 12;
  localparam int NCH  = 4;

  logic        clk;
  logic        rst_n;
  logic [1:0]  strap_start_lvl;
  logic        strap_spin_en;
  logic        strap_wdog_en;
  logic [1:0]  strap_wdog_sel;
  logic        bus_act;
  logic        host_wr_valid;
  logic [1:0]  host_wr_ch;
  logic [7:0]  host_wr_code;
  logic [31:0] drive_code;
  logic        force_full;

  int tests = 0;
  int fails = 0;
  int since = 0;
  logic [7:0] mcode [NCH];
  logic       mforced;
  logic       cur_wen;
  logic [1:0] cur_sel;

  fan_watchdog_ctrl #(.NUM_CH(NCH), .CLK_HZ(HZ), .SPIN_CYCLES(SPIN)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .strap_start_lvl(strap_start_lvl), .strap_spin_en(strap_spin_en),
    .strap_wdog_en(strap_wdog_en), .strap_wdog_sel(strap_wdog_sel),
    .bus_act(bus_act), .host_wr_valid(host_wr_valid),
    .host_wr_ch(host_wr_ch), .host_wr_code(host_wr_code),
    .drive_code(drive_code), .force_full(force_full)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [7:0] lvl_code(input logic [1:0] l);
    if (l == 2'b00) return 8'h00;
    if (l == 2'b01) return 8'hC0;
    return 8'hFF;
  endfunction

  function automatic int tmo_cycles(input logic [1:0] s);
    if (s == 2'b00) return 2 * HZ;
    if (s == 2'b01) return 6 * HZ;
    return 10 * HZ;
  endfunction

  function automatic logic [31:0] exp_vec();
    logic [31:0] v;
    for (int c = 0; c < NCH; c++) v[c*8 +: 8] = mforced ? 8'hFF : mcode[c];
    return v;
  endfunction

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    since += n;
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic chk_drive(input string req, input logic [31:0] expv);
    chk(drive_code === expv, req, drive_code, expv);
  endtask

  task automatic chk_force(input string req, input logic e);
    chk(force_full === e, req, {31'd0, force_full}, {31'd0, e});
  endtask

  task automatic do_reset(input logic [1:0] lvl, input logic spin, input logic wen, input logic [1:0] sel);
    rst_n = 1'b0;
    strap_start_lvl = lvl; strap_spin_en = spin;
    strap_wdog_en = wen; strap_wdog_sel = sel;
    bus_act = 1'b0; host_wr_valid = 1'b0;
    cur_wen = wen; cur_sel = sel; mforced = 1'b0;
    tick(3);
    chk_drive("R1 in reset", 32'hFFFF_FFFF);
    chk_force("R1 in reset", 1'b0);
    rst_n = 1'b1;
    tick(1);
    chk_drive("R1 before capture", 32'hFFFF_FFFF);
    tick(2);
    since = 0;
    for (int c = 0; c < NCH; c++) mcode[c] = lvl_code(lvl);
    if (spin) begin
      chk_drive("R3 spin start", 32'hFFFF_FFFF);
      tick(SPIN - 1);
      chk_drive("R3 spin last cycle", 32'hFFFF_FFFF);
      tick(1);
      chk_drive("R3 R2 level after spin", exp_vec());
    end else begin
      chk_drive("R2 R3 level at capture", exp_vec());
    end
  endtask

  task automatic act_pulse();
    bus_act = 1'b1;
    tick(1);
    bus_act = 1'b0;
    since = 0;
  endtask

  task automatic host_write(input logic [1:0] ch, input logic [7:0] code);
    host_wr_valid = 1'b1; host_wr_ch = ch; host_wr_code = code;
    tick(1);
    host_wr_valid = 1'b0;
    since = 0;
    mcode[ch] = code;
    mforced = 1'b0;
    chk_force("R7 write clears", 1'b0);
    chk_drive("R4 write lands", exp_vec());
  endtask

  task automatic wait_timeout();
    int rem;
    rem = tmo_cycles(cur_sel) - since;
    tick(rem - 1);
    chk_force("R5 one cycle before timeout", 1'b0);
    tick(1);
    chk_force("R5 at timeout", 1'b1);
    mforced = 1'b1;
    chk_drive("R7 forced full", exp_vec());
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    host_wr_ch = 2'd0; host_wr_code = 8'd0;

    // directed: 75 % start, spin-up, 2 s timeout, strap change ignored
    do_reset(2'b01, 1'b1, 1'b1, 2'b00);
    strap_start_lvl = 2'b00; strap_wdog_sel = 2'b11; strap_wdog_en = 1'b0;
    tick(3);
    chk_drive("R10 strap change ignored", exp_vec());
    wait_timeout();
    act_pulse();
    chk_force("R8 activity keeps force", 1'b1);
    chk_drive("R8 still full", 32'hFFFF_FFFF);
    host_write(2'd2, 8'h55);
    chk_drive("R7 R4 codes restored", {8'hC0, 8'h55, 8'hC0, 8'hC0});

    // directed: full start, 6 s, activity just under the window
    do_reset(2'b10, 1'b0, 1'b1, 2'b01);
    for (int k = 0; k < 3; k++) begin
      tick(tmo_cycles(2'b01) - since - 1);
      chk_force("R6 no timeout with activity", 1'b0);
      act_pulse();
    end
    wait_timeout();

    // directed: watchdog off, each channel written alone
    do_reset(2'b00, 1'b0, 1'b0, 2'b00);
    tick(120);
    chk_force("R9 disabled never forces", 1'b0);
    chk_drive("R9 R2 off level kept", 32'h0000_0000);
    for (int c = 0; c < NCH; c++) host_write(c[1:0], 8'h11 * (c + 1));

    // directed: 10 s via 2'b10, level 2'b11
    do_reset(2'b11, 1'b0, 1'b1, 2'b10);
    wait_timeout();

    // random
    for (int it = 0; it < 8; it++) begin
      logic [1:0] l;
      logic [1:0] s;
      logic sp;
      logic we;
      l = 2'($urandom); s = 2'($urandom);
      sp = 1'($urandom); we = 1'($urandom);
      do_reset(l, sp, we, s);
      for (int k = 0; k < 6; k++) begin
        int lim;
        lim = tmo_cycles(s) - since - 1;
        if (lim > 0) tick($urandom % lim);
        if ($urandom % 2) host_write(2'($urandom), 8'($urandom));
        else act_pulse();
        chk_force("R6 random activity", 1'b0);
      end
      if (we) wait_timeout();
      else begin
        tick(tmo_cycles(s) + 3);
        chk_force("R9 random disabled", 1'b0);
      end
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule